// File: doc/BRIEF.md
# Stop-Mode Wake Recovery Controller

This block keeps a small microcontroller's stop mode and its way out of it. A one-byte control word sits at extended register address 0Bh in register bank F. Software picks a wake source, the level that counts as a wake, whether a reset delay follows recovery, and how the system/timer clock is derived from the crystal. When the core asks to stop, the block gates off the system clock enable and watches the chosen source. When a qualified wake arrives it starts the clock enable again, holds the core in an internal reset for a short or a long period, and sets a sticky recovery flag that only power-on clears.

The system/timer clock is not a gated clock. It is a single-cycle enable pulse on the crystal clock. The pulse comes every second crystal cycle by default, or every cycle when the divide-by-2 is bypassed. An optional stage divides it by a further 16. Stop recovery turns that extra divider off again and keeps every other setting.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While `por_n` is low, and for one clock after it is sampled high, `core_rst_n` is 0. After that `core_rst_n` is 1, `stopped` is 0, `stop_flag` is 0 and `sclk_en` pulses once every 2 clocks.
- R2: A write with `wr_en`=1, `wr_bank`=4'hF and `wr_addr`=8'h0B loads the control word: bit 6 sets the wake level, bit 5 enables the reset delay, bits 4:2 select the source, bit 1 bypasses the divide-by-2 and bit 0 enables the divide-by-16. Bit 7 is not writable. A write to any other bank or address changes nothing.
- R3: With bit 1 at 0, `sclk_en` pulses every 2 clocks. With bit 1 at 1, it is high every clock. With bit 0 at 1, the pulse spacing grows by a factor of 16, giving 32 and 16 clocks.
- R4: `stop_req` sampled high while `core_rst_n` is 1 and the block is running sets `stopped` on the next clock. While `stopped` is 1, `sclk_en` stays 0.
- R5: The source codes in bits 4:2 are: 000 none; 001 `gpa_in[0]`; 010 `gpa_in[1]`; 011 `gpa_in[2]`; 100 `gpa_in[3]`; 101 `gpb_in[7]`; 110 the NOR of `gpb_in[3:0]`; 111 the NOR of `gpb_in[7:0]`.
- R6: A selected source wakes the block when its value equals bit 6: 0 means a low level wakes, 1 means a high level wakes. The default after reset is 0.
- R7: The source passes through a two-stage synchronizer and must match the wake level on two consecutive clocks while stopped. A change applied before clock edge E0 clears `stopped` at edge E3. A match that lasts a single clock never wakes the block.
- R8: After a wake, `core_rst_n` is 0 for RST_DELAY clocks (default 64) when bit 5 is 1, and for exactly 1 clock when bit 5 is 0.
- R9: A wake sets `stop_flag` to 1 and clears bit 0 (divide-by-16). The other fields keep their values.
- R10: `por_n` low clears `stop_flag` and restores the defaults (bit 5 at 1, all other bits at 0). `ext_rst_n` low restores the same defaults and leaves the block stopped no longer, but it keeps `stop_flag` unchanged.
- R11: Register writes made while `stopped` is 1 are ignored.
- R12: With source code 000, no pin activity ends stop mode. Only a reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_n | input | 1 | External reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 4 | Register bank of the write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data |
| stop_req | input | 1 | Core request to enter stop mode |
| gpa_in | input | 4 | Wake-capable pins, group A |
| gpb_in | input | 8 | Wake-capable pins, group B |
| stopped | output | 1 | Block is in stop mode |
| core_rst_n | output | 1 | Internal core reset, active low |
| sclk_en | output | 1 | System/timer clock enable pulse |
| stop_flag | output | 1 | Sticky stop-recovery flag (readable bit 7) |

## Verification
The bench applies a one-clock glitch on the wake pin. A design that qualifies the wake on a single sample would leave stop mode on that glitch. It measures the exact wake latency and the length of the reset hold. Wrong synchronizer depth or an off-by-one delay counter would shift those counts. It also makes a write during stop that would both flip the polarity and change the clock divider; a design that accepted that write would wake at once on an idle pin or show the wrong pulse spacing. The last checks cover the NOR groups and the flag's behaviour on external reset and on power-on reset. A design that decoded the wrong nibble, or cleared the flag on every reset, would fail those checks.

// File: rtl/swc_pkg.sv
// Package: shared types of the stop-mode wake controller.
// Assumes: the control word layout below is fixed by software.
package swc_pkg;

    // Sequencer states: core held in reset, running, or stopped.
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } swc_state_e;

    // Wake source codes held in bits 4:2 of the control word.
    typedef enum logic [2:0] {
        SRC_NONE     = 3'd0,
        SRC_GPA0     = 3'd1,
        SRC_GPA1     = 3'd2,
        SRC_GPA2     = 3'd3,
        SRC_GPA3     = 3'd4,
        SRC_GPB7     = 3'd5,
        SRC_GPB_LO   = 3'd6,
        SRC_GPB_ALL  = 3'd7
    } swc_src_e;

    // Writable part of the control word, bit 6 down to bit 0.
    typedef struct packed {
        logic     wake_hi;   // bit 6: 1 = high level wakes
        logic     dly_en;    // bit 5: long reset hold after wake
        swc_src_e src;       // bits 4:2: wake source
        logic     xtal_full; // bit 1: bypass divide-by-2
        logic     slow_en;   // bit 0: extra divide-by-16
    } swc_cfg_t;

    localparam swc_cfg_t CFG_DEFAULT = '{
        wake_hi:   1'b0,
        dly_en:    1'b1,
        src:       SRC_NONE,
        xtal_full: 1'b0,
        slow_en:   1'b0
    };

endpackage

// File: rtl/swc_cfg_reg.sv
// Module: control word and sticky recovery flag.
// Does: decodes writes at one bank/address and stores the writable bits.
// Sets the flag on a wake and clears the slow divider at the same time.
// Assumes: synchronous active-low resets; power-on has priority over
// the external reset, and only power-on clears the flag.
module swc_cfg_reg
    import swc_pkg::*;
#(
    parameter int              BANK_W   = 4,
    parameter int              ADDR_W   = 8,
    parameter logic [BANK_W-1:0] REG_BANK = 4'hF,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0B
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [6:0]        wr_bits,
    input  logic              is_stopped,
    input  logic              recover,
    output swc_cfg_t          cfg,
    output logic              stop_flag
);

    logic wr_hit;

    // Write decode: right bank, right address, and not in stop mode.
    always_comb begin
        wr_hit = wr_en && (wr_bank == REG_BANK) && (wr_addr == REG_ADDR)
                 && !is_stopped;
    end

    // Control word update with reset, recovery and write priority.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cfg <= CFG_DEFAULT;
        end else if (!ext_rst_n) begin
            cfg <= CFG_DEFAULT;
        end else if (recover) begin
            cfg.slow_en <= 1'b0;
        end else if (wr_hit) begin
            cfg <= swc_cfg_t'(wr_bits);
        end
    end

    // Sticky flag: power-on clears it, a wake sets it, else it holds.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            stop_flag <= 1'b0;
        end else if (ext_rst_n && recover) begin
            stop_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/swc_wake_det.sv
// Module: wake source select, synchronizer and level qualifier.
// Does: picks one of eight sources, synchronizes it, and raises wake when
// the synchronized level has matched the wake level for MATCH_CYCLES
// consecutive clocks while armed.
// Assumes: the source and level settings do not change while armed.
module swc_wake_det
    import swc_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MATCH_CYCLES = 2,
    parameter int GPA_W        = 4,
    parameter int GPB_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  swc_src_e         src,
    input  logic             wake_hi,
    input  logic [GPA_W-1:0] gpa_in,
    input  logic [GPB_W-1:0] gpb_in,
    input  logic             armed,
    output logic             wake
);

    localparam int CNT_W = (MATCH_CYCLES > 1) ? $clog2(MATCH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MATCH_CYCLES - 1);
    localparam int GPB_HALF = GPB_W / 2;

    logic                   raw_src;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_ok;
    logic [CNT_W-1:0]       match_cnt;

    // Source multiplexer, including the two NOR groups.
    always_comb begin
        unique case (src)
            SRC_GPA0:    raw_src = gpa_in[0];
            SRC_GPA1:    raw_src = gpa_in[1];
            SRC_GPA2:    raw_src = gpa_in[2];
            SRC_GPA3:    raw_src = gpa_in[3];
            SRC_GPB7:    raw_src = gpb_in[GPB_W-1];
            SRC_GPB_LO:  raw_src = ~|gpb_in[GPB_HALF-1:0];
            SRC_GPB_ALL: raw_src = ~|gpb_in;
            default:     raw_src = 1'b0;
        endcase
    end

    // Synchronizer shift chain for the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= raw_src;
        end
    end

    // Level compare; source code none never matches.
    always_comb begin
        level_ok = (src != SRC_NONE) && (sync_q[SYNC_STAGES-1] == wake_hi);
    end

    // Consecutive-match counter, cleared on any mismatch or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_cnt <= '0;
        end else if (armed && level_ok) begin
            if (match_cnt != CNT_LAST) begin
                match_cnt <= match_cnt + 1'b1;
            end
        end else begin
            match_cnt <= '0;
        end
    end

    // Wake when the current sample extends a long enough run.
    always_comb begin
        wake = armed && level_ok && (match_cnt == CNT_LAST);
    end

endmodule

// File: rtl/swc_clk_gen.sv
// Module: system/timer clock enable generator.
// Does: emits single-cycle enable pulses every crystal cycle or every
// other one, optionally divided by SLOW_DIV more; frozen while not running.
// Assumes: the enable is consumed as a clock enable, never as a clock.
module swc_clk_gen #(
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic xtal_full,
    input  logic slow_en,
    output logic tick
);

    logic half_q;
    logic base_tick;

    // Divide-by-2 phase toggle, held while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (run) begin
            half_q <= ~half_q;
        end
    end

    // Base rate: every clock when bypassed, else every second clock.
    always_comb begin
        base_tick = run && (xtal_full || half_q);
    end

    generate
        if (SLOW_DIV > 1) begin : g_slow
            localparam int SW = $clog2(SLOW_DIV);
            localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
            logic [SW-1:0] slow_cnt;

            // Free-running count of base pulses for the slow divider.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slow_cnt <= '0;
                end else if (base_tick) begin
                    slow_cnt <= (slow_cnt == SLOW_LAST) ? '0 : slow_cnt + 1'b1;
                end
            end

            // Output pulse: every base pulse, or every SLOW_DIV-th one.
            always_comb begin
                tick = base_tick && (!slow_en || (slow_cnt == SLOW_LAST));
            end
        end else begin : g_noslow
            logic unused_slow;
            // No slow stage configured: pass the base rate straight through.
            always_comb begin
                unused_slow = slow_en;
                tick        = base_tick;
            end
        end
    endgenerate

endmodule

// File: rtl/swc_seq.sv
// Module: stop/run/hold sequencer with the reset-delay counter.
// Does: enters stop on request, leaves it on wake, and holds the core in
// reset for RST_DELAY clocks (or one clock) afterwards.
// Assumes: rst_n combines power-on and external reset; RST_DELAY >= 1.
module swc_seq
    import swc_pkg::*;
#(
    parameter int RST_DELAY = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake,
    input  logic dly_en,
    output logic stopped,
    output logic core_rst_n
);

    localparam int CW = $clog2(RST_DELAY + 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [CW-1:0] CNT_LONG = CW'(RST_DELAY);

    swc_state_e      state;
    logic [CW-1:0]   hold_cnt;

    // State and hold counter; a reset leaves one clock of hold behind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HOLD;
            hold_cnt <= CNT_ONE;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (hold_cnt <= CNT_ONE) begin
                        state    <= ST_RUN;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (stop_req) begin
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (wake) begin
                        state    <= ST_HOLD;
                        hold_cnt <= dly_en ? CNT_LONG : CNT_ONE;
                    end
                end
                default: begin
                    state    <= ST_HOLD;
                    hold_cnt <= CNT_ONE;
                end
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        stopped    = (state == ST_STOP);
        core_rst_n = (state != ST_HOLD);
    end

endmodule

// File: rtl/stop_wake_ctrl.sv
// Module: top of the stop-mode wake recovery controller.
// Does: ties the control word, wake detector, sequencer and clock enable
// generator together.
// Assumes: everything runs on the crystal clock; resets are synchronous.
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int RST_DELAY    = 64,
    parameter int SYNC_STAGES  = 2,
    parameter int MATCH_CYCLES = 2,
    parameter int SLOW_DIV     = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_bank,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       stop_req,
    input  logic [3:0] gpa_in,
    input  logic [7:0] gpb_in,
    output logic       stopped,
    output logic       core_rst_n,
    output logic       sclk_en,
    output logic       stop_flag
);

    logic     rst_n;
    logic     wake;
    logic     unused_ro_bit;
    swc_cfg_t cfg;

    // Combined reset for everything but the flag; bit 7 is read-only.
    always_comb begin
        rst_n         = por_n && ext_rst_n;
        unused_ro_bit = wr_data[7];
    end

    swc_cfg_reg #(
        .BANK_W   (4),
        .ADDR_W   (8),
        .REG_BANK (4'hF),
        .REG_ADDR (8'h0B)
    ) i_cfg (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst_n  (ext_rst_n),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .wr_bits    (wr_data[6:0]),
        .is_stopped (stopped),
        .recover    (wake),
        .cfg        (cfg),
        .stop_flag  (stop_flag)
    );

    swc_wake_det #(
        .SYNC_STAGES  (SYNC_STAGES),
        .MATCH_CYCLES (MATCH_CYCLES),
        .GPA_W        (4),
        .GPB_W        (8)
    ) i_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (cfg.src),
        .wake_hi (cfg.wake_hi),
        .gpa_in  (gpa_in),
        .gpb_in  (gpb_in),
        .armed   (stopped),
        .wake    (wake)
    );

    swc_seq #(
        .RST_DELAY (RST_DELAY)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .wake       (wake),
        .dly_en     (cfg.dly_en),
        .stopped    (stopped),
        .core_rst_n (core_rst_n)
    );

    swc_clk_gen #(
        .SLOW_DIV (SLOW_DIV)
    ) i_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!stopped),
        .xtal_full (cfg.xtal_full),
        .slow_en   (cfg.slow_en),
        .tick      (sclk_en)
    );

endmodule

// File: rtl/swc_checker.sv
// Module: property checker for the stop-mode wake controller, bound to
// the top. Observes ports only.
module swc_checker (
    input logic clk,
    input logic por_n,
    input logic ext_rst_n,
    input logic stop_req,
    input logic stopped,
    input logic core_rst_n,
    input logic sclk_en,
    input logic stop_flag
);

    logic rst_n;
    logic seen_clk = 1'b0;

    // Combined reset seen at the ports.
    always_comb begin
        rst_n = por_n && ext_rst_n;
    end

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
    end

    AST_POR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!seen_clk)
        !por_n |=> !stop_flag); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        stop_flag |=> stop_flag); // R10

    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !stopped && core_rst_n) |=> stopped); // R4

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !sclk_en); // R4

    AST_HOLD_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stopped) |-> !core_rst_n); // R8

    AST_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stopped) |-> stop_flag); // R9

endmodule

bind stop_wake_ctrl swc_checker i_swc_checker (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .stop_req   (stop_req),
    .stopped    (stopped),
    .core_rst_n (core_rst_n),
    .sclk_en    (sclk_en),
    .stop_flag  (stop_flag)
);

// File: tb/test_stop_wake_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected reset-hold lengths plus direct checks.
module test_stop_wake_ctrl;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_bank = 4'h0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       stop_req = 1'b0;
    logic [3:0] gpa_in = 4'hF;
    logic [7:0] gpb_in = 8'h00;
    logic       stopped, core_rst_n, sclk_en, stop_flag;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    int exp_hold[$];
    int low_cnt = 0;

    always #2.5 clk = ~clk;

    stop_wake_ctrl i_stop_wake_ctrl (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wr_en(wr_en),
        .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .stop_req(stop_req), .gpa_in(gpa_in), .gpb_in(gpb_in),
        .stopped(stopped), .core_rst_n(core_rst_n), .sclk_en(sclk_en),
        .stop_flag(stop_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic [3:0] b = 4'hF,
                      input logic [7:0] a = 8'h0B);
        wr_en = 1'b1; wr_bank = b; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R4 stop entry", stopped, 1);
    endtask

    // Spacing in clocks between two sclk_en pulses (second interval).
    task automatic period(output int p);
        int n;
        p = -1;
        for (int k = 0; k < 2; k++) begin
            n = 0;
            while (!sclk_en && n < 200) begin @(negedge clk); n++; end
            @(negedge clk);
            n = 1;
            while (!sclk_en && n < 200) begin @(negedge clk); n++; end
            p = n;
        end
    endtask

    task automatic wait_sb();
        int n = 0;
        while (exp_hold.size() > 0 && n < 500) begin @(negedge clk); n++; end
        check("R8 scoreboard drained", exp_hold.size(), 0);
    endtask

    // Monitor: measures each low stretch of core_rst_n and compares it.
    always @(negedge clk) begin
        if (!core_rst_n) begin
            low_cnt++;
        end else begin
            if (low_cnt > 0 && exp_hold.size() > 0) begin
                check("R8 reset hold length", low_cnt, exp_hold.pop_front());
            end
            low_cnt = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int p;
        cyc(3);
        por_n = 1'b1;
        check("R1 hold during release", core_rst_n, 0);
        @(negedge clk);
        check("R1 core released", core_rst_n, 1);
        check("R1 not stopped", stopped, 0);
        check("R1 flag clear", stop_flag, 0);
        period(p); check("R1 default spacing", p, 2);

        // Divider modes
        wr(8'h22); period(p); check("R3 bypass spacing", p, 1);
        wr(8'h23); period(p); check("R3 bypass plus slow", p, 16);
        wr(8'h21); period(p); check("R3 div2 plus slow", p, 32);
        wr(8'h22, 4'hF, 8'h0C); period(p); check("R2 wrong address ignored", p, 32);
        wr(8'h22, 4'hE, 8'h0B); period(p); check("R2 wrong bank ignored", p, 32);

        // Source gpa_in[0], low level, long hold, slow on
        gpa_in = 4'hF;
        wr(8'h25);
        enter_stop();
        p = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); p += sclk_en; end
        check("R4 no enable while stopped", p, 0);
        gpa_in[0] = 1'b0; @(negedge clk); gpa_in[0] = 1'b1;
        cyc(8);
        check("R7 glitch ignored", stopped, 1);
        exp_hold.push_back(64);
        gpa_in[0] = 1'b0;
        cyc(3);
        check("R7 still stopped before E3", stopped, 1);
        @(negedge clk);
        check("R7 exit at E3", stopped, 0);
        check("R9 flag set", stop_flag, 1);
        wait_sb();
        period(p); check("R9 slow divider cleared", p, 2);

        // Retained fields: same source, level and long hold again
        gpa_in[0] = 1'b1; cyc(4);
        enter_stop();
        cyc(6);
        check("R9 source kept, idle pin no wake", stopped, 1);
        exp_hold.push_back(64);
        gpa_in[0] = 1'b0; cyc(5);
        check("R9 kept fields wake", stopped, 0);
        wait_sb();

        // gpb_in[7], high level, short hold
        gpb_in = 8'h00;
        wr(8'h54);
        enter_stop();
        cyc(8);
        check("R6 low level ignored when high selected", stopped, 1);
        exp_hold.push_back(1);
        gpb_in[7] = 1'b1; cyc(5);
        check("R5 gpb7 high wakes", stopped, 0);
        wait_sb();

        // NOR of the low nibble, high level
        gpb_in = 8'h01;
        wr(8'h58);
        enter_stop();
        cyc(8);
        check("R5 low nibble busy no wake", stopped, 1);
        exp_hold.push_back(1);
        gpb_in = 8'hF0; cyc(5);
        check("R5 low nibble NOR wakes", stopped, 0);
        wait_sb();

        // NOR of all eight bits, high level
        wr(8'h5C);
        enter_stop();
        cyc(8);
        check("R5 upper bits block full NOR", stopped, 1);
        exp_hold.push_back(1);
        gpb_in = 8'h00; cyc(5);
        check("R5 full NOR wakes", stopped, 0);
        wait_sb();

        // Writes during stop are ignored
        gpa_in = 4'hF;
        wr(8'h04);
        enter_stop();
        wr(8'h46);
        cyc(8);
        check("R11 polarity write ignored", stopped, 1);
        exp_hold.push_back(1);
        gpa_in[0] = 1'b0; cyc(5);
        check("R11 old level still wakes", stopped, 0);
        wait_sb();
        period(p); check("R11 divider write ignored", p, 2);

        // Source none: only a reset ends stop
        wr(8'h22);
        enter_stop();
        for (int i = 0; i < 6; i++) begin
            gpa_in = ~gpa_in; gpb_in = ~gpb_in; cyc(3);
        end
        check("R12 pins never wake", stopped, 1);
        ext_rst_n = 1'b0; cyc(3);
        check("R10 ext reset leaves stop", stopped, 0);
        check("R10 ext reset keeps flag", stop_flag, 1);
        ext_rst_n = 1'b1; cyc(2);
        period(p); check("R10 ext reset restores defaults", p, 2);

        por_n = 1'b0; cyc(2);
        por_n = 1'b1; cyc(2);
        check("R10 power-on clears flag", stop_flag, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule